// File: doc/BRIEF.md
# Sticky FIFO-Error and Event Status Word

This block holds a 13-bit read-only status word for a multimedia bridge. It collects sticky error flags from two video FIFOs and four audio FIFOs, and sticky threshold flags from four event counters. It also passes two live gate signals straight through. Each sticky flag is set by a one-cycle event pulse and stays set until a clear reaches it.

There are two clear routes. The first is a DMA-side event: a reload of the video DMA base address, or a restart of one audio DMA channel. The second is a software write-one to a grouped clear bit in a separate interrupt status register. That register's decode is outside this block and arrives here as one strobe per group. If a set and a clear reach a flag in the same cycle, the set wins, so no event is lost.

Each flag is a two-state machine. In FLAG_CLR, a set pulse moves the flag to FLAG_SET. In FLAG_SET, a clear with no set pulse in the same cycle moves it back to FLAG_CLR. In every other case the flag stays in its current state. An active-low synchronous reset forces every flag to FLAG_CLR. Reading the word has no side effects.

Top module: `fifo_err_status`

## Requirements
- R1: While `rst_n` is low at a clock edge, every sticky bit (12..7, 3..0) becomes 0, whatever the event inputs are doing.
- R2: A pulse on `vid_err_evt[1]` (video FIFO 2 overflow or underflow) sets bit 12, and a pulse on `vid_err_evt[0]` (video FIFO 1 overflow) sets bit 11. The bit reads 1 from the next cycle and stays 1 with no further pulse.
- R3: A pulse on `vid_dma_reload` or on `clr_vid_w1` clears bits 12 and 11 on the next cycle.
- R4: Pulses on `aud_err_evt[3]`, `[2]`, `[1]` and `[0]` set bits 10, 9, 8 and 7 respectively. These are audio input FIFO 2 underflow, audio output FIFO 2 overflow, audio input FIFO 1 underflow and audio output FIFO 1 overflow. The flags are sticky.
- R5: `aud_restart[1]` (channel 2) clears only bits 10 and 9, and `aud_restart[0]` (channel 1) clears only bits 8 and 7.
- R6: A pulse on `clr_aud_w1` clears all four audio bits 10..7.
- R7: Pulses on `cnt_evt[3]`, `[2]`, `[1]` and `[0]` (event counters 5, 4, 2 and 1 above threshold) set bits 3, 2, 1 and 0. Only `clr_cnt_w1` clears them.
- R8: Bit 6 always reads 0. Bit 5 equals `vgate` and bit 4 equals `hgate` in the same cycle, with no stickiness.
- R9: When a set pulse and any clear reach the same flag in one cycle, the flag is 1 on the next cycle.
- R10: A clear for one group has no effect on the flags of any other group. DMA strobes never touch the counter flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_err_evt | input | 2 | Video error pulses: [1] FIFO 2 over/underflow, [0] FIFO 1 overflow |
| aud_err_evt | input | 4 | Audio error pulses: [3] in2 under, [2] out2 over, [1] in1 under, [0] out1 over |
| cnt_evt | input | 4 | Counter threshold pulses: [3] cnt5, [2] cnt4, [1] cnt2, [0] cnt1 |
| vid_dma_reload | input | 1 | Video DMA base-address reload strobe |
| aud_restart | input | 2 | Audio DMA restart strobes: [1] channel 2, [0] channel 1 |
| clr_vid_w1 | input | 1 | Software write-one clear for the video group |
| clr_aud_w1 | input | 1 | Software write-one clear for the audio group |
| clr_cnt_w1 | input | 1 | Software write-one clear for the counter group |
| vgate | input | 1 | Live vertical gate |
| hgate | input | 1 | Live line-qualifier gate |
| status_o | output | 13 | Status word |

## Verification
The hardest case to reach is a set pulse that coincides with a clear of the same flag. The worst form is a clear arriving by two routes at once, for example a channel restart plus the audio write-one, while a neighbouring flag in the same group is being cleared. Directed steps build exactly these collisions. A long pseudo-random sweep then drives every event and strobe bit with low, independent probabilities, so that sets, DMA clears and software clears overlap in many combinations. After every cycle the whole word is compared with an arithmetic mask model.

// File: rtl/fes_pkg.sv
package fes_pkg;
    localparam int VID_N    = 2;
    localparam int AUD_N    = 4;
    localparam int CNT_N    = 4;
    localparam int STATUS_W = VID_N + AUD_N + 1 + 2 + CNT_N;
    localparam int CNT_LSB  = 0;
    localparam int HG_BIT   = CNT_LSB + CNT_N;
    localparam int VG_BIT   = HG_BIT + 1;
    localparam int RSV_BIT  = VG_BIT + 1;
    localparam int AUD_LSB  = RSV_BIT + 1;
    localparam int VID_LSB  = AUD_LSB + AUD_N;

    typedef enum logic {
        FLAG_CLR = 1'b0,
        FLAG_SET = 1'b1
    } flag_state_t;
endpackage

// File: rtl/fes_sticky_cell.sv
module fes_sticky_cell
    import fes_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_CLR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLR: if (set_i)           state_d = FLAG_SET;
            FLAG_SET: if (clr_i && !set_i) state_d = FLAG_CLR;
            default:                       state_d = FLAG_CLR;
        endcase
    end

    always_comb flag_o = (state_q == FLAG_SET);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R3
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/fes_flag_group.sv
module fes_flag_group #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] flags_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        fes_sticky_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_i[i]),
            .clr_i (clr_i[i]),
            .flag_o(flags_o[i])
        );
    end
endmodule

// File: rtl/fifo_err_status.sv
module fifo_err_status
    import fes_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [VID_N-1:0]    vid_err_evt,
    input  logic [AUD_N-1:0]    aud_err_evt,
    input  logic [CNT_N-1:0]    cnt_evt,
    input  logic                vid_dma_reload,
    input  logic [1:0]          aud_restart,
    input  logic                clr_vid_w1,
    input  logic                clr_aud_w1,
    input  logic                clr_cnt_w1,
    input  logic                vgate,
    input  logic                hgate,
    output logic [STATUS_W-1:0] status_o
);
    localparam int AUD_PER_CH = AUD_N / 2;

    logic [VID_N-1:0] vid_clr, vid_flags;
    logic [AUD_N-1:0] aud_clr, aud_flags;
    logic [CNT_N-1:0] cnt_clr, cnt_flags;

    always_comb vid_clr = {VID_N{vid_dma_reload | clr_vid_w1}};
    always_comb cnt_clr = {CNT_N{clr_cnt_w1}};

    for (genvar c = 0; c < 2; c++) begin : g_aud_ch
        assign aud_clr[c*AUD_PER_CH +: AUD_PER_CH] =
            {AUD_PER_CH{aud_restart[c] | clr_aud_w1}};
    end

    fes_flag_group #(.WIDTH(VID_N)) u_vid (
        .clk(clk), .rst_n(rst_n), .set_i(vid_err_evt), .clr_i(vid_clr), .flags_o(vid_flags)
    );
    fes_flag_group #(.WIDTH(AUD_N)) u_aud (
        .clk(clk), .rst_n(rst_n), .set_i(aud_err_evt), .clr_i(aud_clr), .flags_o(aud_flags)
    );
    fes_flag_group #(.WIDTH(CNT_N)) u_cnt (
        .clk(clk), .rst_n(rst_n), .set_i(cnt_evt), .clr_i(cnt_clr), .flags_o(cnt_flags)
    );

    always_comb begin
        status_o                         = '0;
        status_o[VID_LSB +: VID_N]       = vid_flags;
        status_o[AUD_LSB +: AUD_N]       = aud_flags;
        status_o[RSV_BIT]                = 1'b0;
        status_o[VG_BIT]                 = vgate;
        status_o[HG_BIT]                 = hgate;
        status_o[CNT_LSB +: CNT_N]       = cnt_flags;
    end

    // R3
    vid_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_dma_reload && vid_err_evt == '0) |=> status_o[VID_LSB +: VID_N] == '0);
    // R5
    aud_ch_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!aud_restart[1] && !clr_aud_w1 && aud_err_evt[3:2] == 2'b00)
        |=> $stable(status_o[AUD_LSB+2 +: 2]));
    // R10
    cnt_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_cnt_w1 && cnt_evt == '0) |=> $stable(status_o[CNT_LSB +: CNT_N]));
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (status_o[VID_LSB +: VID_N] == '0 && status_o[AUD_LSB +: AUD_N] == '0
                    && status_o[CNT_LSB +: CNT_N] == '0));
endmodule

// File: tb/fifo_err_status_bench.sv
module fifo_err_status_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  vid_err_evt = '0;
    logic [3:0]  aud_err_evt = '0;
    logic [3:0]  cnt_evt = '0;
    logic        vid_dma_reload = 1'b0;
    logic [1:0]  aud_restart = '0;
    logic        clr_vid_w1 = 1'b0, clr_aud_w1 = 1'b0, clr_cnt_w1 = 1'b0;
    logic        vgate = 1'b0, hgate = 1'b0;
    logic [12:0] status_o;

    int checks = 0;
    int failures = 0;
    logic [1:0] m_vid = '0;
    logic [3:0] m_aud = '0;
    logic [3:0] m_cnt = '0;
    logic [31:0] rng = 32'h1234_abcd;

    always #5 clk = ~clk;

    fifo_err_status u_fifo_err_status (
        .clk(clk), .rst_n(rst_n), .vid_err_evt(vid_err_evt), .aud_err_evt(aud_err_evt),
        .cnt_evt(cnt_evt), .vid_dma_reload(vid_dma_reload), .aud_restart(aud_restart),
        .clr_vid_w1(clr_vid_w1), .clr_aud_w1(clr_aud_w1), .clr_cnt_w1(clr_cnt_w1),
        .vgate(vgate), .hgate(hgate), .status_o(status_o)
    );

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    task automatic check(input string tag, input logic [12:0] exp);
        checks++;
        if (status_o !== exp) begin
            failures++;
            $display("FAIL %s: status=%013b expected=%013b", tag, status_o, exp);
        end
    endtask

    // called at a negedge: drive, pass one rising edge, compare at the next negedge
    task automatic step(input string tag, input logic [1:0] v, input logic [3:0] a,
                        input logic [3:0] c, input logic rel, input logic [1:0] rs,
                        input logic cv, input logic ca, input logic cc,
                        input logic vg, input logic hg);
        logic [3:0] amask;
        vid_err_evt = v; aud_err_evt = a; cnt_evt = c; vid_dma_reload = rel;
        aud_restart = rs; clr_vid_w1 = cv; clr_aud_w1 = ca; clr_cnt_w1 = cc;
        vgate = vg; hgate = hg;
        amask = {{2{rs[1] | ca}}, {2{rs[0] | ca}}};
        if (!rst_n) begin
            m_vid = '0; m_aud = '0; m_cnt = '0;
        end else begin
            m_vid = (m_vid & ~{2{rel | cv}}) | v;
            m_aud = (m_aud & ~amask) | a;
            m_cnt = (m_cnt & ~{4{cc}}) | c;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, {m_vid, m_aud, 1'b0, vg, hg, m_cnt});
    endtask

    task automatic idle(input string tag);
        step(tag, 2'b00, 4'h0, 4'h0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, vgate, hgate);
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog: expired, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: events during reset leave sticky bits at 0; gates still live
        step("R1", 2'b11, 4'hF, 4'hF, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        step("R1", 2'b11, 4'hF, 4'hF, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        rst_n = 1'b1;
        idle("R1");
        // R2: video flag mapping and stickiness
        step("R2", 2'b10, 4'h0, 4'h0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        idle("R2");
        step("R2", 2'b01, 4'h0, 4'h0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        idle("R2");
        // R4 / R7: audio and counter mapping
        for (int i = 0; i < 4; i++) begin
            step("R4", 2'b00, 4'h1 << i, 4'h0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            step("R7", 2'b00, 4'h0, 4'h1 << i, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        end
        // R10: DMA strobes leave counter flags; video clear leaves audio
        step("R10", 2'b00, 4'h0, 4'h0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        // R3: write-one clear of video
        step("R3", 2'b11, 4'h0, 4'h0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R3", 2'b00, 4'h0, 4'h0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R5: channel 1 restart touches bits 8,7 only
        step("R5", 2'b00, 4'h0, 4'h0, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R5", 2'b00, 4'h3, 4'h0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R5", 2'b00, 4'h0, 4'h0, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        // R6: audio write-one
        step("R6", 2'b00, 4'hC, 4'h0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R6", 2'b00, 4'h0, 4'h0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        // R7: counter write-one
        step("R7", 2'b00, 4'h0, 4'h0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        // R8: live gates, all four combinations
        for (int g = 0; g < 4; g++)
            step("R8", 2'b00, 4'h0, 4'h0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, g[1], g[0]);
        // R9: set colliding with double-route clears
        step("R9", 2'b11, 4'hF, 4'hF, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R9", 2'b01, 4'h4, 4'h2, 1'b1, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        step("R9", 2'b10, 4'h1, 4'h8, 1'b1, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        // R10: pseudo-random sweep of overlapping sets and clears
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r1, r2;
            rng = next_rng(rng); r1 = rng;
            rng = next_rng(rng); r2 = rng;
            step("R10", r1[1:0] & r1[3:2], r1[7:4] & r1[11:8], r1[15:12] & r1[19:16],
                 &r2[2:0], {&r2[5:3], &r2[8:6]}, &r2[11:9], &r2[14:12], &r2[17:15],
                 r2[20], r2[21]);
        end
        // R1: reset again with flags set
        step("R1", 2'b11, 4'hF, 4'hF, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b0;
        step("R1", 2'b11, 4'hF, 4'hF, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule